// File: doc/BRIEF.md
# Low-Voltage Detect Status and Control Register

This block is the 8-bit software-visible register that sits between a supply-voltage detector and the rest of a chip. It captures trip events from the comparator in a sticky flag. Software clears that flag by writing a one to an acknowledge bit. The block raises an interrupt request when the flag is set and interrupts are enabled. It also drives the enable and mode controls that go back to the detector and to the reset generator.

The three control bits (detector enable, reset-on-trip enable, keep-alive in stop mode) all come out of reset set to one. The first bus write after reset loads them, and that write arms an internal lock that freezes them until the next reset. The interrupt-enable and acknowledge bits stay writable at all times.

The comparator output `det_i` is a level from the analog side. A detect event is its low-to-high transition, sampled on the clock, while the detector enable is 1. The analog detector, its thresholds and the reset generator lie outside the block.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x1C: bits 4, 3 and 2 are 1 and every other bit is 0. `det_en_o`, `rst_en_o` and `stop_en_o` are 1, and `flag_o`, `irq_o` and `rst_req_o` are 0.
- R2: A rising edge on `det_i` while the detector enable (bit 2) is 1 sets the flag (bit 7) at the next clock edge. The flag stays set after `det_i` falls. Bus writes to bit 7 do not change it.
- R3: While the detector enable is 0, rising edges on `det_i` neither set the flag nor pulse `rst_req_o`.
- R4: A write with bit 6 = 1 clears the flag. A write with bit 6 = 0 leaves the flag unchanged. Bit 6 always reads 0.
- R5: When a detect event and a write with bit 6 = 1 happen in the same cycle, the flag ends up set.
- R6: Bit 5 (interrupt enable) takes the value of every write and reads back what was last written.
- R7: `irq_o` is registered. In each cycle it equals the AND of the flag and bit 5 as they stood one cycle earlier.
- R8: The first write after reset loads bits 4:2 (bit 4 reset enable, bit 3 stop-mode enable, bit 2 detector enable). Every later write leaves those bits unchanged until the next reset.
- R9: Bits 1:0 always read 0, whatever was written to them.
- R10: A detect event while the reset enable (bit 4) is 1 drives `rst_req_o` high for exactly one cycle, in the same cycle that the flag becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| det_i | input | 1 | Detector comparator output (level) |
| sel_i | input | 1 | Register select |
| wr_i | input | 1 | Write strobe, qualified by sel_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| flag_o | output | 1 | Sticky detect flag |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle reset request to the reset generator |
| det_en_o | output | 1 | Detector enable |
| rst_en_o | output | 1 | Reset-on-detect enable |
| stop_en_o | output | 1 | Detector stays active in stop mode |

## Verification
The bench targets the cycle in which an acknowledge write and a new detect event coincide. A design that lets the clear win there drops the event, and the flag reads 0. It also targets the write-once lock. It checks that the first write, which may carry only interrupt-enable and acknowledge bits, still loads and freezes the configuration. It checks that a second write leaves those bits alone while bit 5 keeps following every write. A lock keyed to the wrong bits, or never armed, shows up as changed read-back. Other directed scenarios expose an interrupt request that is combinational rather than delayed by one cycle, a reset request held longer than one cycle, events accepted while the detector is disabled, and a non-zero read of bit 6 or bits 1:0.

// File: rtl/lvd_reg_pkg.sv
package lvd_reg_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned FLAG_BIT   = 7;
  localparam int unsigned ACK_BIT    = 6;
  localparam int unsigned IE_BIT     = 5;
  localparam int unsigned CFG_LO     = 2;
  localparam int unsigned CFG_W      = 3;

  // field order matches bits 4..2
  typedef struct packed {
    logic rst_en;
    logic stop_en;
    logic det_en;
  } cfg_t;

  localparam cfg_t CFG_RST = '{rst_en: 1'b1, stop_en: 1'b1, det_en: 1'b1};
endpackage

// File: rtl/lvd_cfg_unit.sv
module lvd_cfg_unit
  import lvd_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic             ie_o
);
  cfg_t cfg_q;
  logic lock_q;
  logic ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      lock_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (wr_en_i) begin
      ie_q   <= wdata_i[IE_BIT];
      lock_q <= 1'b1;
      if (!lock_q) cfg_q <= cfg_t'(wdata_i[CFG_LO +: CFG_W]);
    end
  end

  assign cfg_o = cfg_q;
  assign ie_o  = ie_q;

  // R8
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(cfg_q));
  // R8
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  // R6
  ie_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ie_o == $past(wdata_i[IE_BIT])));
endmodule

// File: rtl/lvd_flag_unit.sv
module lvd_flag_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  input  logic det_en_i,
  input  logic rst_en_i,
  input  logic ack_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o,
  output logic rst_req_o
);
  logic det_q, flag_q, irq_q, rst_req_q;
  logic evt;

  assign evt = det_i & ~det_q & det_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q     <= 1'b0;
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      det_q     <= det_i;
      // event wins over a same-cycle acknowledge
      if (evt)        flag_q <= 1'b1;
      else if (ack_i) flag_q <= 1'b0;
      irq_q     <= flag_q & ie_i;
      rst_req_q <= evt & rst_en_i;
    end
  end

  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_req_q;

  // R2
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i && !det_q && det_en_i) |=> flag_o);
  // R4
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(det_i && !det_q && det_en_i)) |=> !flag_o);
  // R3
  no_stray_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !det_en_i) |=> !flag_o);
  // R7
  irq_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(flag_o && ie_i)));
  // R10
  rst_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
  import lvd_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             det_i,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             det_en_o,
  output logic             rst_en_o,
  output logic             stop_en_o
);
  logic wr_en, ack, ie, flag;
  cfg_t cfg;

  assign wr_en = sel_i & wr_i;
  assign ack   = wr_en & wdata_i[ACK_BIT];

  lvd_cfg_unit u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .wdata_i (wdata_i),
    .cfg_o   (cfg),
    .ie_o    (ie)
  );

  lvd_flag_unit u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .det_i     (det_i),
    .det_en_i  (cfg.det_en),
    .rst_en_i  (cfg.rst_en),
    .ack_i     (ack),
    .ie_i      (ie),
    .flag_o    (flag),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  // ack and bits below the config field read as zero
  always_comb begin
    rdata_o                  = '0;
    rdata_o[FLAG_BIT]        = flag;
    rdata_o[IE_BIT]          = ie;
    rdata_o[CFG_LO +: CFG_W] = cfg;
  end

  assign flag_o    = flag;
  assign det_en_o  = cfg.det_en;
  assign rst_en_o  = cfg.rst_en;
  assign stop_en_o = cfg.stop_en;

  // R10
  rst_req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (flag_o && $past(rst_en_o)));
endmodule

// File: tb/lvd_ctrl_reg_tb.sv
module lvd_ctrl_reg_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       det_i = 1'b0, sel_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic flag_o, irq_o, rst_req_o, det_en_o, rst_en_o, stop_en_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lvd_ctrl_reg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .det_i(det_i), .sel_i(sel_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .flag_o(flag_o), .irq_o(irq_o),
    .rst_req_o(rst_req_o), .det_en_o(det_en_o), .rst_en_o(rst_en_o),
    .stop_en_o(stop_en_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // drive at negedge, committed at the following posedge, return at next negedge
  task automatic bus_write(input logic [7:0] d);
    @(negedge clk); sel_i = 1'b1; wr_i = 1'b1; wdata_i = d;
    @(negedge clk); sel_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic det_pulse();
    @(negedge clk); det_i = 1'b1;
    @(negedge clk); det_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata_o, 8'h1C);
    chk("R1 outs", {flag_o, irq_o, rst_req_o, det_en_o, rst_en_o, stop_en_o}, 8'b000111);
  endtask

  task automatic t_detect();
    det_pulse();
    chk("R2 flag set", rdata_o, 8'h9C);
    chk("R10 rst_req pulse", {7'd0, rst_req_o}, 8'd1);
    @(negedge clk);
    chk("R10 rst_req one cycle", {7'd0, rst_req_o}, 8'd0);
    chk("R2 flag sticky", {7'd0, flag_o}, 8'd1);
    chk("R7 irq off when ie=0", {7'd0, irq_o}, 8'd0);
  endtask

  task automatic t_first_write();
    bus_write(8'h24); // ie=1, det_en only, bit7=0, bit6=0
    chk("R8 R2 R4 first write", rdata_o, 8'hA4);
    chk("R8 cfg outs", {det_en_o, rst_en_o, stop_en_o}, 8'b100);
    chk("R7 irq registered", {7'd0, irq_o}, 8'd0);
    @(negedge clk);
    chk("R7 irq asserted", {7'd0, irq_o}, 8'd1);
  endtask

  task automatic t_locked();
    bus_write(8'h1C);
    chk("R8 cfg locked, R6 ie cleared", rdata_o, 8'h84);
    bus_write(8'h3F);
    chk("R8 still locked, R6 ie set, R9", rdata_o, 8'hA4);
  endtask

  task automatic t_ack();
    bus_write(8'h60);
    chk("R4 ack clears", rdata_o, 8'h24);
    chk("R7 irq lags flag", {7'd0, irq_o}, 8'd1);
    @(negedge clk);
    chk("R7 irq drops", {7'd0, irq_o}, 8'd0);
  endtask

  task automatic t_no_rst_req();
    det_pulse();
    chk("R10 no rst_req when disabled", {7'd0, rst_req_o}, 8'd0);
    chk("R2 flag set again", {7'd0, flag_o}, 8'd1);
    bus_write(8'h40);
    chk("R4 clear", {7'd0, flag_o}, 8'd0);
  endtask

  task automatic t_collide();
    @(negedge clk); det_i = 1'b1; sel_i = 1'b1; wr_i = 1'b1; wdata_i = 8'h60;
    @(negedge clk); det_i = 1'b0; sel_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
    chk("R5 event beats ack", {7'd0, flag_o}, 8'd1);
    bus_write(8'h40);
    chk("R5 later ack clears", {7'd0, flag_o}, 8'd0);
  endtask

  task automatic t_disabled();
    do_reset();
    t_reset();
    bus_write(8'h03);
    chk("R9 R8 cfg cleared", rdata_o, 8'h00);
    chk("R8 outs off", {det_en_o, rst_en_o, stop_en_o}, 8'b000);
    det_pulse();
    chk("R3 no flag", {7'd0, flag_o}, 8'd0);
    chk("R3 no rst_req", {7'd0, rst_req_o}, 8'd0);
    bus_write(8'h1C);
    chk("R8 relock after reset", rdata_o, 8'h00);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_detect();
    t_first_write();
    t_locked();
    t_ack();
    t_no_rst_req();
    t_collide();
    t_disabled();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule